// File: doc/BRIEF.md
# Bidirectional Endpoint-Reversing Timer

This block is a 16-bit timer that sweeps back and forth between zero and a programmable ceiling. It reverses direction at each end and marks every arrival at an endpoint with a one-clock event pulse. A system uses it as a triangle-wave time base. The zero event and the ceiling event bound each half period.

Counting runs only while `enable` is high. The rising edge of `enable` sets the starting point, chosen by a 2-bit preset selector. Selector 0 places the count on the ceiling and starts a downward sweep. Selector 2 clears the count and starts an upward sweep. Selectors 1 and 3 resume from the held count and direction. The ceiling for an upward sweep is latched, so a new ceiling written mid-sweep takes effect only at the next reversal at the top.

Top module: `tri_sweep_timer`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `count` is 0, `countingUp` is 0 (down), and both event pulses are 0.
- R2: On the first clock edge where `enable` is seen high after being low, with `presetSel` = 0, `count` takes the value of `loadValue` and `countingUp` becomes 0. No event pulse is raised by this preset.
- R3: On that enable edge with `presetSel` = 2, `count` becomes 0 and `countingUp` becomes 1. No event pulse is raised by this preset.
- R4: On that enable edge with `presetSel` = 1 or 3, `count` and `countingUp` keep their values.
- R5: On each later enabled edge while counting down, `count` drops by one. When it reaches 0, `zeroPulse` is high in the same cycle that `count` shows 0, and `countingUp` becomes 1.
- R6: On each later enabled edge while counting up, `count` rises by one. When it reaches the latched ceiling, `loadPulse` is high in the same cycle that `count` shows the ceiling, and `countingUp` becomes 0.
- R7: Each event pulse lasts exactly one cycle, except in the zero-ceiling case of R9.
- R8: An edge with `enable` low leaves `count` and `countingUp` unchanged and leaves both pulses at 0.
- R9: If the latched ceiling is 0, each enabled counting edge holds `count` at 0 and raises both `zeroPulse` and `loadPulse`.
- R10: The ceiling is latched from `loadValue` on every enable edge and on every arrival at the ceiling. A change to `loadValue` at any other time does not alter the ceiling of the sweep in progress.
- R11: While counting up, `count` never passes the latched ceiling. A step that would reach or pass it lands on the ceiling and raises `loadPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; its rising edge applies the preset |
| loadValue | input | 16 | Ceiling of the sweep |
| presetSel | input | 2 | Start choice on enable: 0 ceiling/down, 2 zero/up, 1 or 3 keep |
| count | output | 16 | Current count |
| countingUp | output | 1 | 1 while counting up, 0 while counting down |
| zeroPulse | output | 1 | One-cycle pulse on arrival at zero |
| loadPulse | output | 1 | One-cycle pulse on arrival at the ceiling |

## Verification
A ceiling arrival and the latching of the next ceiling happen on the same edge. A ceiling arrival can also coincide with a resumed count that lies above a lowered ceiling. To provoke the first, the bench changes `loadValue` in the middle of an upward sweep. It then checks that the current peak uses the old value and the following peak uses the new one. For the second, it pauses an upward sweep, resumes it with a smaller ceiling, and checks that the next step lands on that ceiling with `loadPulse` high and the direction reversed. With a zero ceiling, both event pulses coincide on every counting cycle, and the bench checks both pulses together.

// File: rtl/tri_sweep_pkg.sv
package tri_sweep_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_TOP  = 2'd0,
    SEL_KEEP = 2'd1,
    SEL_BASE = 2'd2,
    SEL_RSVD = 2'd3
  } presetSel_e;

  typedef struct packed {
    logic armed;      // enable edge seen: latch ceiling
    logic presetTop;  // jump to ceiling, head down
    logic presetBase; // jump to zero, head up
    logic step;       // ordinary counting edge
  } sweepStrobe_t;
endpackage

// File: rtl/tri_sweep_ctrl.sv
module tri_sweep_ctrl
  import tri_sweep_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] presetSel,
  output sweepStrobe_t     strobe
);
  logic enableQ;
  logic enRise;

  always_ff @(posedge clk) begin
    if (!rstN) enableQ <= 1'b0;
    else       enableQ <= enable;
  end

  assign enRise = enable & ~enableQ;

  always_comb begin
    strobe            = '0;
    strobe.armed      = enRise;
    strobe.presetTop  = enRise && (presetSel == SEL_TOP);
    strobe.presetBase = enRise && (presetSel == SEL_BASE);
    strobe.step       = enable & enableQ;
  end

  // R4: the enable edge and a counting step never share a cycle
  p_edge_not_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armed |-> !strobe.step);
  // R8: no counting strobe while disabled
  p_idle_no_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(strobe.step || strobe.armed));
endmodule

// File: rtl/tri_sweep_datapath.sv
module tri_sweep_datapath
  import tri_sweep_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sweepStrobe_t     strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             countingUp,
  output logic             zeroPulse,
  output logic             loadPulse
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] ceilReg;
  logic             ceilIsZero;
  logic             hitTop;
  logic             hitBase;

  assign ceilIsZero = (ceilReg == ZERO);
  assign hitTop     = (count >= ceilReg - ONE);
  assign hitBase    = (count <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= ZERO;
      countingUp <= 1'b0;
      ceilReg    <= ZERO;
      zeroPulse  <= 1'b0;
      loadPulse  <= 1'b0;
    end else begin
      zeroPulse <= 1'b0;
      loadPulse <= 1'b0;
      if (strobe.armed) begin
        ceilReg <= loadValue;
        if (strobe.presetTop) begin
          count      <= loadValue;
          countingUp <= 1'b0;
        end else if (strobe.presetBase) begin
          count      <= ZERO;
          countingUp <= 1'b1;
        end
      end else if (strobe.step) begin
        if (ceilIsZero) begin
          count     <= ZERO;
          zeroPulse <= 1'b1;
          loadPulse <= 1'b1;
        end else if (countingUp) begin
          if (hitTop) begin
            count      <= ceilReg;
            countingUp <= 1'b0;
            loadPulse  <= 1'b1;
            ceilReg    <= loadValue;
          end else begin
            count <= count + ONE;
          end
        end else begin
          if (hitBase) begin
            count      <= ZERO;
            countingUp <= 1'b1;
            zeroPulse  <= 1'b1;
          end else begin
            count <= count - ONE;
          end
        end
      end
    end
  end

  // R2: ceiling preset loads the live ceiling and heads down
  p_preset_top_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.presetTop |=> (count == $past(loadValue)) && !countingUp && !zeroPulse && !loadPulse);
  // R3: zero preset clears and heads up
  p_preset_base_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.presetBase |=> (count == ZERO) && countingUp && !zeroPulse && !loadPulse);
  // R4: keep selection resumes unchanged
  p_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && !strobe.presetTop && !strobe.presetBase) |=> $stable(count) && $stable(countingUp));
  // R5: zero event only at zero
  p_zero_at_base_r5: assert property (@(posedge clk) disable iff (!rstN)
    zeroPulse |-> (count == ZERO));
  // R6: ceiling event shows the ceiling that was in force
  p_load_at_top_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loadPulse && !zeroPulse) |-> (count == $past(ceilReg)) && !countingUp);
  // R7: a lone zero event is never repeated in the next cycle
  p_zero_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (zeroPulse && !loadPulse) |=> !zeroPulse);
  // R8: disabled cycles hold and stay quiet
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.armed || strobe.step) |=> $stable(count) && $stable(countingUp) && !zeroPulse && !loadPulse);
endmodule

// File: rtl/tri_sweep_timer.sv
module tri_sweep_timer
  import tri_sweep_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [SEL_W-1:0] presetSel,
  output logic [CNT_W-1:0] count,
  output logic             countingUp,
  output logic             zeroPulse,
  output logic             loadPulse
);
  sweepStrobe_t strobe;

  tri_sweep_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .presetSel (presetSel),
    .strobe    (strobe)
  );

  tri_sweep_datapath #(.CNT_W(CNT_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loadValue  (loadValue),
    .count      (count),
    .countingUp (countingUp),
    .zeroPulse  (zeroPulse),
    .loadPulse  (loadPulse)
  );
endmodule

// File: tb/tri_sweep_timer_test.sv
`timescale 1ns/1ps
module tri_sweep_timer_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [15:0] loadValue;
  logic [1:0]  presetSel;
  logic [15:0] count;
  logic        countingUp, zeroPulse, loadPulse;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  tri_sweep_timer uut (
    .clk(clk), .rstN(rstN), .enable(enable), .loadValue(loadValue),
    .presetSel(presetSel), .count(count), .countingUp(countingUp),
    .zeroPulse(zeroPulse), .loadPulse(loadPulse)
  );

  // {req[3:0], en, sel[1:0], load[15:0], expCount[15:0], expUp, expZero, expLoad}
  localparam int NV = 42;
  localparam logic [41:0] VECS [NV] = '{
    {4'd8,  1'b0, 2'd0, 16'd3,  16'd0, 1'b0, 1'b0, 1'b0}, // R8 idle
    {4'd2,  1'b1, 2'd0, 16'd3,  16'd3, 1'b0, 1'b0, 1'b0}, // R2 top preset
    {4'd5,  1'b1, 2'd0, 16'd3,  16'd2, 1'b0, 1'b0, 1'b0},
    {4'd5,  1'b1, 2'd0, 16'd3,  16'd1, 1'b0, 1'b0, 1'b0},
    {4'd5,  1'b1, 2'd0, 16'd3,  16'd0, 1'b1, 1'b1, 1'b0}, // R5 zero event
    {4'd6,  1'b1, 2'd0, 16'd3,  16'd1, 1'b1, 1'b0, 1'b0}, // R7 pulse ends
    {4'd6,  1'b1, 2'd0, 16'd3,  16'd2, 1'b1, 1'b0, 1'b0},
    {4'd6,  1'b1, 2'd0, 16'd3,  16'd3, 1'b0, 1'b0, 1'b1}, // R6 load event
    {4'd7,  1'b1, 2'd0, 16'd3,  16'd2, 1'b0, 1'b0, 1'b0}, // R7
    {4'd8,  1'b0, 2'd0, 16'd3,  16'd2, 1'b0, 1'b0, 1'b0}, // R8 hold
    {4'd8,  1'b0, 2'd2, 16'd3,  16'd2, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 2'd2, 16'd3,  16'd0, 1'b1, 1'b0, 1'b0}, // R3 zero preset
    {4'd6,  1'b1, 2'd2, 16'd3,  16'd1, 1'b1, 1'b0, 1'b0},
    {4'd6,  1'b1, 2'd2, 16'd3,  16'd2, 1'b1, 1'b0, 1'b0},
    {4'd10, 1'b1, 2'd2, 16'd5,  16'd3, 1'b0, 1'b0, 1'b1}, // R10 old ceiling
    {4'd5,  1'b1, 2'd2, 16'd5,  16'd2, 1'b0, 1'b0, 1'b0},
    {4'd5,  1'b1, 2'd2, 16'd5,  16'd1, 1'b0, 1'b0, 1'b0},
    {4'd5,  1'b1, 2'd2, 16'd5,  16'd0, 1'b1, 1'b1, 1'b0},
    {4'd10, 1'b1, 2'd2, 16'd5,  16'd1, 1'b1, 1'b0, 1'b0},
    {4'd10, 1'b1, 2'd2, 16'd5,  16'd2, 1'b1, 1'b0, 1'b0},
    {4'd10, 1'b1, 2'd2, 16'd5,  16'd3, 1'b1, 1'b0, 1'b0}, // R10 passes 3
    {4'd10, 1'b1, 2'd2, 16'd5,  16'd4, 1'b1, 1'b0, 1'b0},
    {4'd10, 1'b1, 2'd2, 16'd5,  16'd5, 1'b0, 1'b0, 1'b1}, // R10 new ceiling
    {4'd8,  1'b0, 2'd1, 16'd5,  16'd5, 1'b0, 1'b0, 1'b0},
    {4'd4,  1'b1, 2'd1, 16'd5,  16'd5, 1'b0, 1'b0, 1'b0}, // R4 keep (1)
    {4'd5,  1'b1, 2'd1, 16'd5,  16'd4, 1'b0, 1'b0, 1'b0},
    {4'd8,  1'b0, 2'd3, 16'd5,  16'd4, 1'b0, 1'b0, 1'b0},
    {4'd4,  1'b1, 2'd3, 16'd5,  16'd4, 1'b0, 1'b0, 1'b0}, // R4 keep (3)
    {4'd5,  1'b1, 2'd3, 16'd5,  16'd3, 1'b0, 1'b0, 1'b0},
    {4'd8,  1'b0, 2'd0, 16'd0,  16'd3, 1'b0, 1'b0, 1'b0},
    {4'd9,  1'b1, 2'd0, 16'd0,  16'd0, 1'b0, 1'b0, 1'b0}, // R9 zero ceiling
    {4'd9,  1'b1, 2'd0, 16'd0,  16'd0, 1'b0, 1'b1, 1'b1},
    {4'd9,  1'b1, 2'd0, 16'd0,  16'd0, 1'b0, 1'b1, 1'b1},
    {4'd8,  1'b0, 2'd0, 16'd0,  16'd0, 1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 2'd2, 16'd10, 16'd0, 1'b1, 1'b0, 1'b0},
    {4'd6,  1'b1, 2'd2, 16'd10, 16'd1, 1'b1, 1'b0, 1'b0},
    {4'd6,  1'b1, 2'd2, 16'd10, 16'd2, 1'b1, 1'b0, 1'b0},
    {4'd8,  1'b0, 2'd1, 16'd1,  16'd2, 1'b1, 1'b0, 1'b0},
    {4'd4,  1'b1, 2'd1, 16'd1,  16'd2, 1'b1, 1'b0, 1'b0}, // R4 resume up
    {4'd11, 1'b1, 2'd1, 16'd1,  16'd1, 1'b0, 1'b0, 1'b1}, // R11 lands on ceiling
    {4'd5,  1'b1, 2'd1, 16'd1,  16'd0, 1'b1, 1'b1, 1'b0},
    {4'd6,  1'b1, 2'd1, 16'd1,  16'd1, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input int req, input logic [15:0] eCnt,
                       input logic eUp, input logic eZ, input logic eL);
    total++;
    if (count !== eCnt || countingUp !== eUp || zeroPulse !== eZ || loadPulse !== eL) begin
      bad++;
      $display("FAIL R%0d: got cnt=%0d up=%0b z=%0b l=%0b, want cnt=%0d up=%0b z=%0b l=%0b",
               req, count, countingUp, zeroPulse, loadPulse, eCnt, eUp, eZ, eL);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; loadValue = 16'd3; presetSel = 2'd0;
    repeat (3) @(negedge clk);
    check(1, 16'd0, 1'b0, 1'b0, 1'b0); // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    check(1, 16'd0, 1'b0, 1'b0, 1'b0); // R1 after release

    for (int i = 0; i < NV; i++) begin
      enable    = VECS[i][37];
      presetSel = VECS[i][36:35];
      loadValue = VECS[i][34:19];
      @(negedge clk);
      check(int'(VECS[i][41:38]), VECS[i][18:3], VECS[i][2], VECS[i][1], VECS[i][0]);
    end

    // R1: reset in the middle of a sweep
    rstN = 1'b0;
    @(negedge clk);
    check(1, 16'd0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1; enable = 1'b0;
    @(negedge clk);

    // R7: ceiling 1 from top preset, pulses alternate one cycle each
    enable = 1'b1; presetSel = 2'd0; loadValue = 16'd1;
    @(negedge clk);
    check(2, 16'd1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(7, 16'd0, 1'b1, 1'b1, 1'b0); // R7 zero arrival
      @(negedge clk);
      check(7, 16'd1, 1'b0, 1'b0, 1'b1); // R7 ceiling arrival
    end

    // R11: large ceiling, top preset of 65535 and one step down
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1; presetSel = 2'd0; loadValue = 16'hFFFF;
    @(negedge clk);
    check(11, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(11, 16'hFFFE, 1'b0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule